// File: doc/BRIEF.md
# Memory Card Bus Phase Sequencer

This block is the host end of a three-wire, half-duplex memory card link: a serial clock, a bidirectional line that carries both commands and data, and a bus-state line that frames every transaction. The host alone starts transfers. A card never begins one, so any card status is fetched with a read that the host issues. For each accepted request the sequencer raises the bus-state line and shifts out an 8-bit packet command. It then lowers the line and releases the data line. It waits for the card to flip the level of that line. If the flip comes, it raises the bus-state line again and moves the requested bytes, then lowers the line to end the transaction.

The data phase can run on the single serial line or on a 4-lane or 8-lane parallel bus. The extra lanes are only used during that phase. Write bytes come from a show-ahead byte source through a take strobe, and read bytes leave through a one-cycle valid strobe. A programmable handshake limit, counted in serial clock periods, bounds the wait for the card. When the limit runs out the transaction ends at once with an error flag. The serial clock runs freely from the system clock. Every change the host makes on the bus lines happens on a falling serial clock edge, and every sample it takes is on a rising edge.

Top module: `mcb_phase_seq`

## Requirements
- R1: During reset and right after it, `req_ready` is 1, `bus_state`, `bus_oe` and `xfer_done` are 0, and `bus_clk` is high.
- R2: `req_ready` is 1 only while the sequencer is idle. A request is taken in a cycle where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the cycle of `xfer_done`.
- R3: At the first falling `bus_clk` edge after acceptance, `bus_state` rises and `bus_oe` goes high. Over the next 8 rising edges, `bus_dout[0]` carries `req_cmd` MSB first. Then `bus_state` falls at the next falling edge.
- R4: While `bus_state` is low after the command, `bus_oe` is 0 and the host samples `bus_din[0]` at each rising edge. The first sample is the reference. At the falling edge after the first sample that differs, `bus_state` rises for the data phase. If the byte count is 0, the transaction instead ends there with `xfer_err` = 0.
- R5: If none of the first `hs_limit` handshake samples (reference included) differs, the transaction ends at the next falling edge with `xfer_done` and `xfer_err` both 1. No data phase is run and `bus_state` stays low.
- R6: For a write (`req_write` = 1), `bus_oe` is 1 in the data phase. `wr_take` pulses once per byte, and `wr_data` is taken in that cycle. Each byte is presented over 8/L rising edges, where L is the lane count.
- R7: For a read, `bus_oe` is 0 in the data phase. The host captures the lanes at each rising edge and pulses `rd_valid` with the assembled byte after its last beat, once per byte, in order.
- R8: After the last data beat, `bus_state` falls at the next falling edge. In that same cycle `xfer_done` pulses with `xfer_err` = 0 and `req_ready` returns to 1.
- R9: `req_width` selects the lanes: 0 gives 1 lane (`bus_dout[0]`, MSB first), 1 gives 4 lanes (`[3:0]`, upper nibble first), and 2 or 3 gives 8 lanes (the whole byte). The command always uses 1 lane. Lanes not in use are driven to 0.
- R10: `bus_clk` toggles every `DIV_HALF` system clocks. `bus_state` changes only in the cycle where `bus_clk` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_cmd | input | 8 | Packet command code |
| req_write | input | 1 | 1 = host sends data, 0 = host receives |
| req_len | input | LEN_W | Byte count of the data phase (0 = none) |
| req_width | input | 2 | Data lane selection |
| hs_limit | input | TMO_W | Handshake limit in serial clock periods |
| wr_data | input | 8 | Next write byte (show-ahead) |
| wr_take | output | 1 | Write byte consumed this cycle |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | rd_data valid for one cycle |
| xfer_done | output | 1 | Transaction finished (one cycle) |
| xfer_err | output | 1 | Handshake limit ran out (valid with xfer_done) |
| bus_clk | output | 1 | Serial clock to the card |
| bus_state | output | 1 | Bus-state framing line |
| bus_dout | output | 8 | Host drive value for the data lanes |
| bus_oe | output | 1 | Host drives the data lanes |
| bus_din | input | 8 | Data lanes as seen at the pads |

## Verification
The bench acts as the card and sweeps every lane setting against both directions and byte counts of 0, 1 and 3. A swapped nibble order or a wrong beat count would corrupt the reassembled bytes or change the number of data clocks. A zero-length request must skip the data phase outright, so a design that raised `bus_state` anyway would show a second framing pulse. The handshake limit is probed on both sides of its edge: a change seen on the very last allowed sample must still win, and one sample later must abort with the error flag. An off-by-one in the limit compare fails one of the two cases. The bench also watches that the host never drives the line during the handshake or a read.

// File: rtl/mcb_pkg.sv
// Shared types and helpers for the memory card bus phase sequencer.
// Assumes a byte-wide data path and lane modes of 1, 4 or 8 lanes.
package mcb_pkg;

    localparam int BYTE_W = 8;
    localparam int CMD_BITS = 8;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ARM  = 3'd1,
        PH_CMD  = 3'd2,
        PH_HSK  = 3'd3,
        PH_DATA = 3'd4
    } phase_e;

    // Index of the last beat of a byte for a lane mode.
    function automatic logic [2:0] last_beat_of(input logic [1:0] mode);
        case (mode)
            2'd0:    return 3'd7;
            2'd1:    return 3'd1;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/mcb_sclk_gen.sv
// Free-running serial clock generator.
// Divides the system clock so that the serial clock toggles every DIV_HALF
// cycles. It flags the cycle in which a falling or rising toggle is
// registered, so that the other logic updates on the same edge.
// Assumes DIV_HALF >= 1.
module mcb_sclk_gen #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic sclk,
    output logic fall_tk,
    output logic rise_tk
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          wrap;

    // Detect the end of a half period.
    always_comb begin
        wrap    = (cnt_q == LAST);
        fall_tk = wrap && sclk;
        rise_tk = wrap && !sclk;
    end

    // Count half periods and toggle the serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sclk  <= 1'b1;
        end else if (wrap) begin
            cnt_q <= '0;
            sclk  <= ~sclk;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/mcb_hsk_timer.sv
// Handshake watcher.
// While active, it samples the data line at each rising serial edge. The
// first sample is kept as the reference, and a later sample that differs
// sets a sticky hit flag. If the sample count reaches the limit without a
// hit, a sticky expired flag is set instead. A hit on the final sample wins.
// clr holds the watcher idle and empties it.
module mcb_hsk_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             active,
    input  logic             rise_tk,
    input  logic             line,
    input  logic [TMO_W-1:0] limit,
    output logic             hit,
    output logic             expired
);
    logic [TMO_W-1:0] cnt_q;
    logic             have_ref_q;
    logic             ref_q;
    logic [TMO_W:0]   cnt_nxt;
    logic             differs;
    logic             sample;

    // Next count and change detection for the current sample.
    always_comb begin
        cnt_nxt = {1'b0, cnt_q} + 1'b1;
        differs = have_ref_q && (line != ref_q);
        sample  = active && rise_tk && !hit && !expired;
    end

    // Track the reference, the sample count and the outcome flags.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q      <= '0;
            have_ref_q <= 1'b0;
            ref_q      <= 1'b0;
            hit        <= 1'b0;
            expired    <= 1'b0;
        end else if (sample) begin
            cnt_q <= cnt_nxt[TMO_W-1:0];
            if (!have_ref_q) begin
                have_ref_q <= 1'b1;
                ref_q      <= line;
            end
            if (differs) begin
                hit <= 1'b1;
            end else if (cnt_nxt >= {1'b0, limit}) begin
                expired <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/mcb_lane_io.sv
// Lane shifter for the data lanes.
// The transmit side loads a byte and presents its leading bits on 1, 4 or
// 8 lanes, shifting them out MSB first. The receive side assembles incoming
// beats into a byte in the same order. Mode 0 = 1 lane, 1 = 4 lanes,
// 2 or 3 = 8 lanes. Lanes not in use read as zero.
module mcb_lane_io
    import mcb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic              shift,
    input  logic              cap,
    input  logic [BYTE_W-1:0] lanes_in,
    output logic [BYTE_W-1:0] lanes_out,
    output logic [BYTE_W-1:0] cap_next
);
    logic [BYTE_W-1:0] tx_q;
    logic [BYTE_W-1:0] rx_q;

    // Present the leading bits of the transmit byte on the active lanes.
    always_comb begin
        case (mode)
            2'd0:    lanes_out = {7'b0, tx_q[7]};
            2'd1:    lanes_out = {4'b0, tx_q[7:4]};
            default: lanes_out = tx_q;
        endcase
    end

    // Merge the incoming beat behind the bits already received.
    always_comb begin
        case (mode)
            2'd0:    cap_next = {rx_q[6:0], lanes_in[0]};
            2'd1:    cap_next = {rx_q[3:0], lanes_in[3:0]};
            default: cap_next = lanes_in;
        endcase
    end

    // Load or advance the transmit register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= load_byte;
        end else if (shift) begin
            case (mode)
                2'd0:    tx_q <= {tx_q[6:0], 1'b0};
                2'd1:    tx_q <= {tx_q[3:0], 4'b0};
                default: tx_q <= '0;
            endcase
        end
    end

    // Accumulate received beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (cap) begin
            rx_q <= cap_next;
        end
    end

endmodule

// File: rtl/mcb_phase_seq.sv
// Host-side phase sequencer for a three-wire memory card bus.
// It accepts one request at a time. It frames the transaction with the
// bus-state line, shifts out the command, waits for the card to flip the
// data line, and then moves req_len bytes on 1, 4 or 8 lanes. All host-side
// line changes fall on falling serial edges, and samples are taken on
// rising edges. Assumes wr_data is valid whenever wr_take is raised
// (show-ahead source), and that rd_valid is always accepted.
module mcb_phase_seq
    import mcb_pkg::*;
#(
    parameter int DIV_HALF = 2,
    parameter int LEN_W    = 4,
    parameter int TMO_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [7:0]       req_cmd,
    input  logic             req_write,
    input  logic [LEN_W-1:0] req_len,
    input  logic [1:0]       req_width,
    input  logic [TMO_W-1:0] hs_limit,
    input  logic [7:0]       wr_data,
    output logic             wr_take,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             xfer_done,
    output logic             xfer_err,
    output logic             bus_clk,
    output logic             bus_state,
    output logic [7:0]       bus_dout,
    output logic             bus_oe,
    input  logic [7:0]       bus_din
);
    localparam logic [LEN_W-1:0] ONE_BYTE = LEN_W'(1);
    localparam logic [2:0]       CMD_LAST = 3'(CMD_BITS - 1);

    phase_e           ph_q;
    logic             bs_q;
    logic             oe_q;
    logic             wr_q;
    logic [7:0]       cmd_q;
    logic [LEN_W-1:0] left_q;
    logic [1:0]       wid_q;
    logic [TMO_W-1:0] lim_q;
    logic [2:0]       beat_q;
    logic [2:0]       rbeat_q;
    logic             done_q;
    logic             err_q;
    logic             rdv_q;
    logic [7:0]       rdd_q;

    logic             fall_tk;
    logic             rise_tk;
    logic             hs_hit;
    logic             hs_exp;
    logic [1:0]       lane_mode;
    logic [2:0]       last_beat;
    logic [7:0]       lanes_out;
    logic [7:0]       cap_next;
    logic             sh_load;
    logic             sh_shift;
    logic [7:0]       sh_byte;
    logic             cap_en;
    logic             take;

    mcb_sclk_gen #(
        .DIV_HALF (DIV_HALF)
    ) u_sclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk    (bus_clk),
        .fall_tk (fall_tk),
        .rise_tk (rise_tk)
    );

    mcb_hsk_timer #(
        .TMO_W (TMO_W)
    ) u_hsk (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ph_q != PH_HSK),
        .active  (ph_q == PH_HSK),
        .rise_tk (rise_tk),
        .line    (bus_din[0]),
        .limit   (lim_q),
        .hit     (hs_hit),
        .expired (hs_exp)
    );

    mcb_lane_io u_lanes (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (lane_mode),
        .load      (sh_load),
        .load_byte (sh_byte),
        .shift     (sh_shift),
        .cap       (cap_en),
        .lanes_in  (bus_din),
        .lanes_out (lanes_out),
        .cap_next  (cap_next)
    );

    // Lane mode and beat limit: the command is always serial.
    always_comb begin
        lane_mode = (ph_q == PH_DATA) ? wid_q : 2'd0;
        last_beat = (ph_q == PH_DATA) ? last_beat_of(wid_q) : CMD_LAST;
    end

    // Byte fetch, shifter control and receive capture strobes.
    always_comb begin
        take = fall_tk && wr_q &&
               (((ph_q == PH_HSK) && hs_hit && (left_q != '0)) ||
                ((ph_q == PH_DATA) && (beat_q == last_beat) && (left_q > ONE_BYTE)));
        sh_load  = (fall_tk && (ph_q == PH_ARM)) || take;
        sh_byte  = (ph_q == PH_ARM) ? cmd_q : wr_data;
        sh_shift = fall_tk &&
                   (((ph_q == PH_CMD) && (beat_q != CMD_LAST)) ||
                    ((ph_q == PH_DATA) && wr_q && (beat_q != last_beat)));
        cap_en   = rise_tk && (ph_q == PH_DATA) && !wr_q;
    end

    // Phase sequencing on falling serial edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_IDLE;
            bs_q   <= 1'b0;
            oe_q   <= 1'b0;
            wr_q   <= 1'b0;
            cmd_q  <= '0;
            left_q <= '0;
            wid_q  <= '0;
            lim_q  <= '0;
            beat_q <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (ph_q)
                PH_IDLE: begin
                    if (req_valid) begin
                        cmd_q  <= req_cmd;
                        wr_q   <= req_write;
                        left_q <= req_len;
                        wid_q  <= req_width;
                        lim_q  <= hs_limit;
                        ph_q   <= PH_ARM;
                    end
                end
                PH_ARM: begin
                    if (fall_tk) begin
                        ph_q   <= PH_CMD;
                        bs_q   <= 1'b1;
                        oe_q   <= 1'b1;
                        beat_q <= '0;
                    end
                end
                PH_CMD: begin
                    if (fall_tk) begin
                        if (beat_q == CMD_LAST) begin
                            ph_q <= PH_HSK;
                            bs_q <= 1'b0;
                            oe_q <= 1'b0;
                        end else begin
                            beat_q <= beat_q + 1'b1;
                        end
                    end
                end
                PH_HSK: begin
                    if (fall_tk) begin
                        if (hs_hit) begin
                            beat_q <= '0;
                            if (left_q == '0) begin
                                ph_q   <= PH_IDLE;
                                done_q <= 1'b1;
                            end else begin
                                ph_q <= PH_DATA;
                                bs_q <= 1'b1;
                                oe_q <= wr_q;
                            end
                        end else if (hs_exp) begin
                            ph_q   <= PH_IDLE;
                            done_q <= 1'b1;
                            err_q  <= 1'b1;
                        end
                    end
                end
                PH_DATA: begin
                    if (fall_tk) begin
                        if (beat_q == last_beat) begin
                            beat_q <= '0;
                            if (left_q == ONE_BYTE) begin
                                ph_q   <= PH_IDLE;
                                bs_q   <= 1'b0;
                                oe_q   <= 1'b0;
                                done_q <= 1'b1;
                            end else begin
                                left_q <= left_q - 1'b1;
                            end
                        end else begin
                            beat_q <= beat_q + 1'b1;
                        end
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // Receive beat counting and byte delivery on rising serial edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbeat_q <= '0;
            rdv_q   <= 1'b0;
            rdd_q   <= '0;
        end else begin
            rdv_q <= 1'b0;
            if (ph_q == PH_HSK) begin
                rbeat_q <= '0;
            end else if (cap_en) begin
                if (rbeat_q == last_beat) begin
                    rbeat_q <= '0;
                    rdv_q   <= 1'b1;
                    rdd_q   <= cap_next;
                end else begin
                    rbeat_q <= rbeat_q + 1'b1;
                end
            end
        end
    end

    // Port outputs.
    always_comb begin
        req_ready = (ph_q == PH_IDLE);
        wr_take   = take;
        rd_data   = rdd_q;
        rd_valid  = rdv_q;
        xfer_done = done_q;
        xfer_err  = err_q;
        bus_state = bs_q;
        bus_oe    = oe_q;
        bus_dout  = oe_q ? lanes_out : 8'h00;
    end

endmodule

// File: rtl/mcb_phase_seq_chk.sv
// Port-level protocol checker for mcb_phase_seq, attached with bind.
// It watches framing, drive-enable and handshake strobes over time.
module mcb_phase_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       wr_take,
    input logic       rd_valid,
    input logic       xfer_done,
    input logic       xfer_err,
    input logic       bus_clk,
    input logic       bus_state,
    input logic       bus_oe
);
    // R10
    bs_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state != $past(bus_state)) |-> $fell(bus_clk));

    // R4
    oe_framed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> bus_state);

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (req_ready && !bus_state && !bus_oe));

    // R5
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_err |-> xfer_done);

    // R6
    take_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_take |=> (bus_state && bus_oe));

    // R7
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (bus_state && !bus_oe));

endmodule

bind mcb_phase_seq mcb_phase_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .wr_take   (wr_take),
    .rd_valid  (rd_valid),
    .xfer_done (xfer_done),
    .xfer_err  (xfer_err),
    .bus_clk   (bus_clk),
    .bus_state (bus_state),
    .bus_oe    (bus_oe)
);

// File: tb/mcb_phase_seq_test.sv
`timescale 1ns/1ps
module mcb_phase_seq_test;
    localparam int DIVH = 2;
    localparam int LW   = 4;
    localparam int TW   = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [7:0]    req_cmd = '0;
    logic          req_write = 1'b0;
    logic [LW-1:0] req_len = '0;
    logic [1:0]    req_width = '0;
    logic [TW-1:0] hs_limit = '0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    bus_din = 8'hFF;
    logic          req_ready, wr_take, rd_valid, xfer_done, xfer_err;
    logic          bus_clk, bus_state, bus_oe;
    logic [7:0]    rd_data, bus_dout;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    mcb_phase_seq #(.DIV_HALF(DIVH), .LEN_W(LW), .TMO_W(TW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_write(req_write), .req_len(req_len),
        .req_width(req_width), .hs_limit(hs_limit), .wr_data(wr_data),
        .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
        .xfer_done(xfer_done), .xfer_err(xfer_err), .bus_clk(bus_clk),
        .bus_state(bus_state), .bus_dout(bus_dout), .bus_oe(bus_oe),
        .bus_din(bus_din)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input logic [7:0] seed, input int k);
        return 8'((int'(seed) + k * 53) & 255) ^ 8'hA5;
    endfunction

    function automatic int lanes_n(input logic [1:0] w);
        return (w == 2'd0) ? 1 : (w == 2'd1) ? 4 : 8;
    endfunction

    // Act as the card for one transaction and score it.
    task automatic run_xfer(input logic [7:0] cmd, input bit wr, input int len,
                            input logic [1:0] w, input int lim, input int hdel,
                            input bit exp_err);
        int L, bpb, ph, ccnt, hcnt, drise, wb, wbytes, wbad, rbeats, rgot, rbad;
        int takes, widx, guard, k, b, sh;
        logic [7:0] csr, wacc, bv;
        bit adv, cmd_oe_bad, lane_bad, hs_oe_bad, d_oe_bad, edge_bad, done, err;
        bit rise, fall, prev_clk, prev_bs;
        L = lanes_n(w); bpb = 8 / L;
        ph = 0; ccnt = 0; hcnt = 0; drise = 0; wb = 0; wbytes = 0; wbad = 0;
        rbeats = 0; rgot = 0; rbad = 0; takes = 0; widx = 0; guard = 0;
        csr = '0; wacc = '0; adv = 0; cmd_oe_bad = 0; lane_bad = 0;
        hs_oe_bad = 0; d_oe_bad = 0; edge_bad = 0; done = 0; err = 0;
        @(negedge clk);
        req_cmd = cmd; req_write = wr; req_len = LW'(len); req_width = w;
        hs_limit = TW'(lim); wr_data = pat(cmd, 0); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R2", "ready while busy", int'(req_ready), 0);
        prev_clk = bus_clk; prev_bs = bus_state;
        while (!done && guard < 4000) begin
            @(negedge clk);
            guard++;
            rise = bus_clk && !prev_clk;
            fall = !bus_clk && prev_clk;
            if (bus_state != prev_bs && !fall) edge_bad = 1;
            if (bus_state && !prev_bs) begin
                if (ph == 0) ph = 1; else if (ph == 2) ph = 3;
            end
            if (!bus_state && prev_bs) begin
                if (ph == 1) ph = 2; else if (ph == 3) ph = 4;
            end
            prev_clk = bus_clk; prev_bs = bus_state;
            if (adv) begin widx++; wr_data = pat(cmd, widx); adv = 0; end
            if (wr_take) begin takes++; adv = 1; end
            case (ph)
                1: begin
                    if (!bus_oe) cmd_oe_bad = 1;
                    if (bus_dout[7:1] != 0) lane_bad = 1;
                    if (rise) begin csr = {csr[6:0], bus_dout[0]}; ccnt++; end
                end
                2: begin
                    if (bus_oe) hs_oe_bad = 1;
                    if (rise) begin
                        hcnt++;
                        if (hcnt == hdel) bus_din[0] = ~bus_din[0];
                    end
                end
                3: begin
                    if (rise) drise++;
                    if (wr) begin
                        if (!bus_oe) d_oe_bad = 1;
                        if (L < 8 && (bus_dout >> L) != 0) lane_bad = 1;
                        if (rise) begin
                            wacc = 8'((wacc << L) | (bus_dout & 8'((1 << L) - 1)));
                            wb++;
                            if (wb == bpb) begin
                                if (wacc != pat(cmd, wbytes)) wbad++;
                                wbytes++; wb = 0;
                            end
                        end
                    end else begin
                        if (bus_oe) d_oe_bad = 1;
                        if (fall && rbeats < len * bpb) begin
                            k = rbeats / bpb; b = rbeats % bpb;
                            bv = pat(cmd, k); sh = 8 - L * (b + 1);
                            bus_din = 8'((bv >> sh) & 8'((1 << L) - 1));
                            rbeats++;
                        end
                    end
                end
                default: ;
            endcase
            if (rd_valid) begin
                if (rd_data != pat(cmd, rgot)) rbad++;
                rgot++;
            end
            if (xfer_done) begin done = 1; err = xfer_err; end
        end
        chk(done, "R8", "completion seen", int'(done), 1);
        chk(csr == cmd && ccnt == 8, "R3", "command bits", int'(csr), int'(cmd));
        chk(!cmd_oe_bad && !lane_bad, "R9", "drive and unused lanes", int'(lane_bad), 0);
        chk(!edge_bad, "R10", "framing on falling edge", int'(edge_bad), 0);
        chk(!hs_oe_bad, "R4", "line released in handshake", int'(hs_oe_bad), 0);
        if (exp_err) begin
            chk(err, "R5", "error flag", int'(err), 1);
            chk(hcnt == lim, "R5", "samples before abort", hcnt, lim);
            chk(ph == 2, "R5", "no data phase", ph, 2);
        end else begin
            chk(!err, "R4", "no error", int'(err), 0);
            chk(hcnt == hdel + 1, "R4", "handshake samples", hcnt, hdel + 1);
            if (len == 0) begin
                chk(ph == 2, "R4", "zero length skips data", ph, 2);
                chk(takes == 0 && rgot == 0, "R4", "no bytes moved", takes + rgot, 0);
            end else begin
                chk(ph == 4, "R8", "framing low after data", ph, 4);
                if (wr) begin
                    chk(drise == len * bpb, "R6", "write data clocks", drise, len * bpb);
                    chk(!d_oe_bad, "R6", "drive in write", int'(d_oe_bad), 0);
                    chk(wbytes == len && wbad == 0, "R6", "write bytes bad", wbad, 0);
                    chk(takes == len, "R6", "byte fetches", takes, len);
                end else begin
                    chk(drise == len * bpb, "R7", "read data clocks", drise, len * bpb);
                    chk(!d_oe_bad, "R7", "release in read", int'(d_oe_bad), 0);
                    chk(rgot == len && rbad == 0, "R7", "read bytes", rgot, len);
                    chk(takes == 0, "R7", "no fetch on read", takes, 0);
                end
            end
        end
        @(negedge clk);
        chk(req_ready, "R2", "ready after done", int'(req_ready), 1);
    endtask

    initial begin
        int t0, span;
        logic c0;
        repeat (3) @(negedge clk);
        chk(req_ready && !bus_state && !bus_oe && !xfer_done && bus_clk,
            "R1", "reset state", int'({req_ready, bus_state, bus_oe, xfer_done, bus_clk}), 5'b10001);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !bus_state && !bus_oe, "R1", "after release", int'(bus_state), 0);
        c0 = bus_clk;
        while (bus_clk == c0) @(negedge clk);
        c0 = bus_clk; span = 0;
        while (bus_clk == c0) begin @(negedge clk); span++; end
        chk(span == DIVH, "R10", "half period", span, DIVH);
        t0 = 0;
        for (int w = 0; w < 3; w++)
            for (int d = 0; d < 2; d++)
                for (int n = 0; n < 3; n++) begin
                    t0++;
                    run_xfer(8'(8'h3C + t0 * 17), d[0], (n == 2) ? 3 : n,
                             2'(w), 20, 2, 1'b0);
                end
        // R9: width code 3 selects 8 lanes
        run_xfer(8'hC3, 1'b1, 2, 2'd3, 20, 3, 1'b0);
        run_xfer(8'h5A, 1'b0, 2, 2'd3, 20, 1, 1'b0);
        // R4: change seen on the last allowed sample still wins
        run_xfer(8'h81, 1'b1, 2, 2'd0, 6, 5, 1'b0);
        // R5: change one sample late aborts
        run_xfer(8'h7E, 1'b1, 2, 2'd1, 6, 6, 1'b1);
        // R5: card never answers
        run_xfer(8'hE7, 1'b0, 3, 2'd2, 15, 10000, 1'b1);
        // R4: earliest possible change
        run_xfer(8'h18, 1'b0, 1, 2'd1, 200, 1, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule